// File: doc/BRIEF.md
# Serial Command Loader Engine

This block turns a byte stream from a serial receiver into loader actions. Each incoming frame is five bytes long: a command byte, then four argument bytes. The engine has an internal store pointer. Depending on the command, it writes a full word or a single byte at that pointer and then advances the pointer. It can also load the pointer with a new value, or raise a one-cycle start request that carries a fixed entry address and a configurable initial stack value. A status lamp output turns on once the engine leaves reset, which shows that it is waiting for input.

Both data paths are valid/ready streams. On the receive side, a byte is taken only on a clock edge where `rx_valid` and `rx_ready` are both high. The engine lowers `rx_ready` while a complete frame is still waiting to be executed. On the memory side, a write request stays asserted with unchanged address, data and lane enables until the memory returns `mem_ready`. While a request is outstanding, no further frame is executed. This back-pressure travels upstream until `rx_ready` drops. The start request is a plain pulse and has no handshake.

Top module: `cmd_loader`

## Requirements
- R1: After reset, `mem_valid` and `run_pulse` are low, `rx_ready` is high, and the store pointer is 0, so the first word write goes to address 0.
- R2: The four argument bytes that follow the command byte form a 32-bit value with the first-received byte as bits [31:24] and the last-received byte as bits [7:0].
- R3: Command 0x00 issues one write with address equal to the pointer, data equal to the argument and `mem_strb` = 4'b1111. The pointer then grows by 4.
- R4: Command 0x01 loads the pointer with the argument and issues no write.
- R5: Command 0x03 issues one write at the pointer with `mem_strb` one-hot at bit position pointer[1:0], and with argument bits [7:0] copied into all four byte lanes of `mem_data`. The pointer then grows by 1 and wraps from 0xFFFFFFFF to 0.
- R6: Command 0x02 raises `run_pulse` for exactly one cycle, with `run_entry` = 0x00400000 and `run_stack` = the STACK_INIT parameter. It issues no write and leaves the pointer unchanged.
- R7: Any command value of 0x04 or above is dropped after its four argument bytes. It issues no write and no run pulse, and the pointer is unchanged.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_data` and `mem_strb` hold their values, and writes complete in command order.
- R9: While a received frame waits for execution, `rx_ready` is low and no byte is consumed.
- R10: `led_on` is low during reset and high from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Engine can take a byte |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Byte address of the write |
| mem_data | output | 32 | Write data |
| mem_strb | output | 4 | Byte-lane enables |
| run_pulse | output | 1 | One-cycle start request |
| run_entry | output | 32 | Start address |
| run_stack | output | 32 | Initial stack value |
| led_on | output | 1 | Ready lamp |

## Verification
The bench keeps the default 32-bit address width and four byte lanes. With these values it can walk all four lane positions of a byte write and drive the pointer through its wrap from 0xFFFFFFFF to 0. It overrides STACK_INIT with a distinctive pattern, 0x1234_5670, so that a stack output tied to a wrong or constant value shows up. It also holds `mem_ready` low across two frames. This makes the stall travel back to `rx_ready` and exposes any reordering of queued writes.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam logic [7:0] OP_WORD = 8'h00;
  localparam logic [7:0] OP_PTR  = 8'h01;
  localparam logic [7:0] OP_RUN  = 8'h02;
  localparam logic [7:0] OP_BYTE = 8'h03;

  typedef enum logic {
    EX_IDLE = 1'b0,
    EX_WAIT = 1'b1
  } ex_state_t;
endpackage

// File: rtl/ldr_frame_asm.sv
module ldr_frame_asm #(
  parameter int ARG_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  output logic                   rx_ready,
  output logic                   frame_valid,
  output logic [7:0]             frame_cmd,
  output logic [8*ARG_BYTES-1:0] frame_arg,
  input  logic                   frame_ready
);
  localparam int ARG_W = 8 * ARG_BYTES;
  localparam int CNT_W = $clog2(ARG_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ARG_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       cmd_q;
  logic [ARG_W-1:0] arg_q;
  logic             full_q;
  logic             take;

  assign rx_ready    = !full_q;
  assign take        = rx_valid && rx_ready;
  assign frame_valid = full_q;
  assign frame_cmd   = cmd_q;
  assign frame_arg   = arg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmd_q  <= '0;
      arg_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (full_q && frame_ready) full_q <= 1'b0;
      if (take) begin
        if (cnt_q == '0) cmd_q <= rx_data;
        else             arg_q <= {arg_q[ARG_W-9:0], rx_data};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R9: a waiting frame stays put and blocks input
  p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && !frame_ready |=> frame_valid && $stable(frame_cmd) && $stable(frame_arg));
  p_no_take_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !rx_ready);
endmodule

// File: rtl/ldr_exec.sv
module ldr_exec
  import ldr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_valid,
  input  logic [7:0]           frame_cmd,
  input  logic [8*LANES-1:0]   frame_arg,
  output logic                 frame_ready,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [8*LANES-1:0]   mem_data,
  output logic [LANES-1:0]     mem_strb,
  output logic                 run_pulse
);
  localparam int DATA_W = 8 * LANES;
  localparam int LANE_W = $clog2(LANES);

  ex_state_t          st_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic [LANES-1:0]   lane_sel;
  logic               accept;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sel[g] = (ptr_q[LANE_W-1:0] == LANE_W'(g));
  end

  assign frame_ready = (st_q == EX_IDLE);
  assign accept      = frame_valid && frame_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= EX_IDLE;
      ptr_q     <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_strb  <= '0;
      run_pulse <= 1'b0;
    end else begin
      run_pulse <= 1'b0;
      if (st_q == EX_WAIT && mem_ready) begin
        mem_valid <= 1'b0;
        st_q      <= EX_IDLE;
      end
      if (accept) begin
        unique case (frame_cmd)
          OP_WORD: begin
            mem_valid <= 1'b1;
            mem_addr  <= ptr_q;
            mem_data  <= frame_arg;
            mem_strb  <= '1;
            ptr_q     <= ptr_q + ADDR_W'(LANES);
            st_q      <= EX_WAIT;
          end
          OP_BYTE: begin
            mem_valid <= 1'b1;
            mem_addr  <= ptr_q;
            mem_data  <= {LANES{frame_arg[7:0]}};
            mem_strb  <= lane_sel;
            ptr_q     <= ptr_q + 1'b1;
            st_q      <= EX_WAIT;
          end
          OP_PTR:  ptr_q     <= ADDR_W'(frame_arg);
          OP_RUN:  run_pulse <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R8: request held under back-pressure
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_strb));
  // R5 / R3: lane enables are either a single lane or all lanes
  p_strb_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_strb) == 1 || mem_strb == {LANES{1'b1}}));
  // R6: start request lasts one cycle
  p_run_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_pulse |=> !run_pulse);
  // R3: word acceptance advances the pointer by the lane count
  p_ptr_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && frame_cmd == OP_WORD |=> ptr_q == $past(ptr_q) + ADDR_W'(LANES));
  // R6 / R7: no write starts from a run or unknown command
  p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && frame_cmd != OP_WORD && frame_cmd != OP_BYTE |=> !mem_valid);
endmodule

// File: rtl/cmd_loader.sv
module cmd_loader #(
  parameter int          ADDR_W     = 32,
  parameter int          LANES      = 4,
  parameter logic [31:0] ENTRY_ADDR = 32'h0040_0000,
  parameter logic [31:0] STACK_INIT = 32'h7FFF_EFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_data,
  output logic [3:0]        mem_strb,
  output logic              run_pulse,
  output logic [31:0]       run_entry,
  output logic [31:0]       run_stack,
  output logic              led_on
);
  localparam int DATA_W = 8 * LANES;

  logic              fr_valid;
  logic              fr_ready;
  logic [7:0]        fr_cmd;
  logic [DATA_W-1:0] fr_arg;
  logic              led_q;

  ldr_frame_asm #(.ARG_BYTES(LANES)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .frame_valid(fr_valid), .frame_cmd(fr_cmd), .frame_arg(fr_arg),
    .frame_ready(fr_ready)
  );

  ldr_exec #(.ADDR_W(ADDR_W), .LANES(LANES)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .frame_valid(fr_valid), .frame_cmd(fr_cmd), .frame_arg(fr_arg),
    .frame_ready(fr_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_strb(mem_strb),
    .run_pulse(run_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= 1'b1;
  end

  assign led_on    = led_q;
  assign run_entry = ENTRY_ADDR;
  assign run_stack = STACK_INIT;

  // R10: lamp on once out of reset
  p_led_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> led_on);
endmodule

// File: tb/cmd_loader_bench.sv
module cmd_loader_bench;
  localparam logic [31:0] STACK = 32'h1234_5670;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_data, run_entry, run_stack;
  logic [3:0]  mem_strb;
  logic        run_pulse, led_on;

  int checks = 0;
  int fails  = 0;

  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [3:0]  log_strb [64];
  int          nwr = 0;
  int          nrun = 0;
  logic        run_wide = 1'b0;
  logic        run_prev = 1'b0;
  logic [31:0] seen_entry = '0, seen_stack = '0;

  always #2.5 clk = ~clk;

  cmd_loader #(.STACK_INIT(STACK)) u_cmd_loader (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_strb(mem_strb),
    .run_pulse(run_pulse), .run_entry(run_entry), .run_stack(run_stack),
    .led_on(led_on)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready && nwr < 64) begin
        log_addr[nwr] = mem_addr;
        log_data[nwr] = mem_data;
        log_strb[nwr] = mem_strb;
        nwr++;
      end
      if (run_pulse) begin
        nrun++;
        seen_entry = run_entry;
        seen_stack = run_stack;
        if (run_prev) run_wide = 1'b1;
      end
      run_prev = run_pulse;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit ok;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    forever begin
      ok = rx_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] cmd, input logic [31:0] arg);
    send_byte(cmd);
    send_byte(arg[31:24]);
    send_byte(arg[23:16]);
    send_byte(arg[15:8]);
    send_byte(arg[7:0]);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_wr(input int idx, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] s, input string tag);
    chk(nwr > idx, {tag, " write count"}, nwr, idx + 1);
    if (nwr > idx) begin
      chk(log_addr[idx] == a, {tag, " addr"}, log_addr[idx], a);
      chk(log_data[idx] == d, {tag, " data"}, log_data[idx], d);
      chk(log_strb[idx] == s, {tag, " strb"}, {28'd0, log_strb[idx]}, {28'd0, s});
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(led_on == 1'b0, "R10 lamp in reset", led_on, 0);
    chk(mem_valid == 1'b0, "R1 mem_valid in reset", mem_valid, 0);
    chk(run_pulse == 1'b0, "R1 run_pulse in reset", run_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 1'b1, "R1 rx_ready after reset", rx_ready, 1);
    chk(led_on == 1'b1, "R10 lamp after reset", led_on, 1);
  endtask

  task automatic t_words();
    send_frame(8'h00, 32'hDEAD_BEEF);
    send_frame(8'h00, 32'h1122_3344);
    settle();
    expect_wr(0, 32'h0, 32'hDEAD_BEEF, 4'hF, "R1 R2 R3 first word");
    expect_wr(1, 32'h4, 32'h1122_3344, 4'hF, "R3 second word");
  endtask

  task automatic t_bytes();
    send_frame(8'h01, 32'h0000_0100);
    settle();
    chk(nwr == 2, "R4 set pointer writes nothing", nwr, 2);
    send_frame(8'h03, 32'hFFFF_FFAB);
    send_frame(8'h03, 32'h0000_00CD);
    send_frame(8'h03, 32'h0000_00EF);
    send_frame(8'h03, 32'h0000_0012);
    send_frame(8'h00, 32'hCAFE_F00D);
    settle();
    expect_wr(2, 32'h100, 32'hABAB_ABAB, 4'b0001, "R4 R5 lane0");
    expect_wr(3, 32'h101, 32'hCDCD_CDCD, 4'b0010, "R5 lane1");
    expect_wr(4, 32'h102, 32'hEFEF_EFEF, 4'b0100, "R5 lane2");
    expect_wr(5, 32'h103, 32'h1212_1212, 4'b1000, "R5 lane3");
    expect_wr(6, 32'h104, 32'hCAFE_F00D, 4'hF, "R5 word after bytes");
  endtask

  task automatic t_ignored();
    send_frame(8'h07, 32'h5555_5555);
    send_frame(8'hFF, 32'h0000_0000);
    settle();
    chk(nwr == 7, "R7 unknown command writes nothing", nwr, 7);
    chk(nrun == 0, "R7 unknown command no run", nrun, 0);
    send_frame(8'h00, 32'hA5A5_0001);
    settle();
    expect_wr(7, 32'h108, 32'hA5A5_0001, 4'hF, "R7 pointer unchanged");
  endtask

  task automatic t_run();
    send_frame(8'h02, 32'h9999_9999);
    settle();
    chk(nrun == 1, "R6 one run pulse", nrun, 1);
    chk(run_wide == 1'b0, "R6 pulse one cycle", run_wide, 0);
    chk(seen_entry == 32'h0040_0000, "R6 entry", seen_entry, 32'h0040_0000);
    chk(seen_stack == STACK, "R6 stack", seen_stack, STACK);
    chk(nwr == 8, "R6 run writes nothing", nwr, 8);
    send_frame(8'h00, 32'h0BAD_F00D);
    settle();
    expect_wr(8, 32'h10C, 32'h0BAD_F00D, 4'hF, "R6 pointer unchanged");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    mem_ready = 1'b0;
    send_frame(8'h00, 32'h1111_0000);
    send_frame(8'h00, 32'h2222_0000);
    repeat (8) @(negedge clk);
    chk(mem_valid == 1'b1, "R8 request held", mem_valid, 1);
    chk(mem_addr == 32'h110, "R8 held addr", mem_addr, 32'h110);
    chk(rx_ready == 1'b0, "R9 rx stalled", rx_ready, 0);
    chk(nwr == 9, "R8 no write while stalled", nwr, 9);
    mem_ready = 1'b1;
    settle();
    expect_wr(9,  32'h110, 32'h1111_0000, 4'hF, "R8 first in order");
    expect_wr(10, 32'h114, 32'h2222_0000, 4'hF, "R8 second in order");
    chk(rx_ready == 1'b1, "R9 rx resumes", rx_ready, 1);
  endtask

  task automatic t_wrap();
    send_frame(8'h01, 32'hFFFF_FFFF);
    send_frame(8'h03, 32'h0000_0077);
    send_frame(8'h00, 32'h600D_600D);
    settle();
    expect_wr(11, 32'hFFFF_FFFF, 32'h7777_7777, 4'b1000, "R5 top byte");
    expect_wr(12, 32'h0, 32'h600D_600D, 4'hF, "R5 pointer wrap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_words();
    t_bytes();
    t_ignored();
    t_run();
    t_backpressure();
    t_wrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule